// File: doc/BRIEF.md
# SD-Host Clock Source Sequencer

This block drives the 2-bit source-select code for two independent SD-host clock channels. Each code picks one of three sources: the fastest (nominally 533 MHz), the middle (nominally 400 MHz) or the slowest (nominally 266 MHz). Software writes a single 32-bit control register. The block then works out a safe route from the present source to the requested one and drives each channel's select output along that route.

Switching directly between the two fastest sources is unsafe. When such a change is requested, the block first moves the channel onto the slowest source, holds it there for `HOLD` cycles, and then applies the target. The all-zero code is never driven. A write that would store it is refused and raises a sticky error flag. Writes use a half-word mask: a lower-half bit changes only when the bit 16 places above it is also set. A write that reaches a channel while it is mid-route is held as that channel's new target. The most recent such write is the one applied when the route ends. The two channels run fully independently.

Top module: `sdclk_src_seq`

## Requirements
- R1: After reset, both select outputs are 2'b01 and the register reads 32'h0000_0011, with both busy bits and the error bit clear.
- R2: A select output never carries 2'b00. A write whose masked result for a field is 2'b00 leaves that field and its output unchanged.
- R3: A change between 2'b01 and 2'b10, in either direction, first drives 2'b11 and only then drives the target.
- R4: A change into or out of 2'b11 is applied directly. The new code appears on the output one cycle after the clock edge that accepts the write.
- R5: During a routed change, the output shows 2'b11 for exactly `HOLD` cycles before the target code appears.
- R6: Channel 0 occupies register bits [1:0] and channel 1 occupies bits [5:4]. A lower-half bit n is written only when data bit n+16 is 1. Bits [31:16] always read as zero.
- R7: Bit 8 (channel 0) and bit 9 (channel 1) read 1 exactly while that channel is holding the intermediate 2'b11 step.
- R8: A field read returns the channel's latest accepted request. A write accepted while the channel is busy does not restart the hold, and the latest such write is applied when the hold ends.
- R9: A refused write sets the sticky error bit 12. Writing data with bits 12 and 28 both set clears it. Writing bit 12 without bit 28 has no effect.
- R10: A routed change on one channel never delays or alters the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; upper half is the per-bit write mask |
| rd_data | output | 32 | Register readback |
| sel0 | output | 2 | Channel 0 source-select code |
| sel1 | output | 2 | Channel 1 source-select code |

## Verification
The assertions take for granted that `wr_en` and `wr_data` are stable and known around each rising edge. They also assume the block leaves reset with no write pending, so every select code they observe was produced by the sequencer from its reset value. The stimulus meets this by changing inputs only on falling edges and by holding reset for several cycles with the write strobe low. Error clears are issued only as whole-word writes, so the stickiness property sees a clean write strobe.

// File: rtl/sdclk_src_seq.sv
module sdclk_src_seq #(
  parameter int HOLD = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [1:0]  sel0,
  output logic [1:0]  sel1
);
  localparam int CW = (HOLD < 2) ? 1 : $clog2(HOLD + 1);

  logic [3:0] sel_v;
  logic [3:0] tgt_v;
  logic [1:0] busy_v;
  logic [1:0] bad;
  logic       err;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [1:0]    cur, tgt, m, d, nxt;
    logic [CW-1:0] cnt;
    logic          busy, hop;

    assign m   = wr_data[16 + 4*c +: 2];
    assign d   = wr_data[4*c +: 2];
    assign nxt = (tgt & ~m) | (d & m);
    assign bad[c] = wr_en && (m != 2'b00) && (nxt == 2'b00);
    assign hop = ((cur ^ tgt) == 2'b11) && (cur != 2'b00) && (tgt != 2'b00);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur  <= 2'b01;
        tgt  <= 2'b01;
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        if (wr_en && (m != 2'b00) && (nxt != 2'b00)) tgt <= nxt;
        else if (tgt == 2'b00) tgt <= 2'b01;

        if (cur == 2'b00) begin
          cur  <= 2'b01;
          busy <= 1'b0;
        end else if (busy) begin
          if (cnt == '0) begin
            cur  <= (tgt == 2'b00) ? 2'b01 : tgt;
            busy <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else if ((tgt != cur) && (tgt != 2'b00)) begin
          if (hop) begin
            cur  <= 2'b11;
            busy <= 1'b1;
            cnt  <= CW'(HOLD - 1);
          end else begin
            cur <= tgt;
          end
        end
      end
    end

    assign sel_v[2*c +: 2] = cur;
    assign tgt_v[2*c +: 2] = tgt;
    assign busy_v[c]       = busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   err <= 1'b0;
    else if (|bad)                                err <= 1'b1;
    else if (wr_en && wr_data[12] && wr_data[28]) err <= 1'b0;
  end

  assign sel0    = sel_v[1:0];
  assign sel1    = sel_v[3:2];
  assign rd_data = {16'h0000, 3'b000, err, 2'b00, busy_v, 2'b00, tgt_v[3:2], 2'b00, tgt_v[1:0]};
endmodule

// File: rtl/sdclk_src_seq_chk.sv
module sdclk_src_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic [1:0]  sel0,
  input logic [1:0]  sel1
);
  a_r2_sel0_nonzero: assert property (@(posedge clk) disable iff (!rst_n) sel0 != 2'b00);
  a_r2_sel1_nonzero: assert property (@(posedge clk) disable iff (!rst_n) sel1 != 2'b00);

  a_r3_ch0_up:   assert property (@(posedge clk) disable iff (!rst_n) (sel0 == 2'b01) |=> (sel0 != 2'b10));
  a_r3_ch0_down: assert property (@(posedge clk) disable iff (!rst_n) (sel0 == 2'b10) |=> (sel0 != 2'b01));
  a_r3_ch1_up:   assert property (@(posedge clk) disable iff (!rst_n) (sel1 == 2'b01) |=> (sel1 != 2'b10));
  a_r3_ch1_down: assert property (@(posedge clk) disable iff (!rst_n) (sel1 == 2'b10) |=> (sel1 != 2'b01));

  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n) rd_data[31:16] == 16'h0000);

  a_r7_busy0_mid: assert property (@(posedge clk) disable iff (!rst_n) rd_data[8] |-> (sel0 == 2'b11));
  a_r7_busy1_mid: assert property (@(posedge clk) disable iff (!rst_n) rd_data[9] |-> (sel1 == 2'b11));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[12] && !(wr_en && wr_data[12] && wr_data[28])) |=> rd_data[12]);
endmodule

bind sdclk_src_seq sdclk_src_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sel0(sel0), .sel1(sel1)
);

// File: tb/sdclk_src_seq_bench.sv
`timescale 1ns/1ps
module sdclk_src_seq_bench;
  localparam int HOLD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [1:0]  sel0, sel1;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdclk_src_seq #(.HOLD(HOLD)) u_sdclk_src_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sel0(sel0), .sel1(sel1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] f0(input logic [1:0] v);
    return 32'h0003_0000 | {30'd0, v};
  endfunction

  function automatic logic [31:0] f1(input logic [1:0] v);
    return 32'h0030_0000 | {26'd0, v, 4'd0};
  endfunction

  task automatic t_reset;
    chk("R1 sel0", {30'd0, sel0}, 32'd1);
    chk("R1 sel1", {30'd0, sel1}, 32'd1);
    chk("R1 readback", rd_data, 32'h0000_0011);
  endtask

  task automatic t_direct;
    wr(f0(2'b11)); step(1);
    chk("R4 to slow", {30'd0, sel0}, 32'd3);
    chk("R4 no busy", {31'd0, rd_data[8]}, 32'd0);
    wr(f0(2'b01)); step(1);
    chk("R4 from slow", {30'd0, sel0}, 32'd1);
  endtask

  task automatic t_through;
    wr(f0(2'b10)); step(1);
    chk("R3 via mid", {30'd0, sel0}, 32'd3);
    chk("R7 busy0", {31'd0, rd_data[8]}, 32'd1);
    chk("R8 field shows request", {30'd0, rd_data[1:0]}, 32'd2);
    for (int i = 1; i < HOLD; i++) begin
      step(1);
      chk("R5 held mid", {30'd0, sel0}, 32'd3);
    end
    step(1);
    chk("R5 target after hold", {30'd0, sel0}, 32'd2);
    chk("R7 busy0 clear", {31'd0, rd_data[8]}, 32'd0);
    wr(f0(2'b01)); step(1);
    chk("R3 back via mid", {30'd0, sel0}, 32'd3);
    step(HOLD);
    chk("R3 back to fast", {30'd0, sel0}, 32'd1);
  endtask

  task automatic t_indep;
    wr(f0(2'b10));
    wr(f1(2'b11)); step(1);
    chk("R10 ch1 direct", {30'd0, sel1}, 32'd3);
    chk("R10 ch0 still mid", {30'd0, sel0}, 32'd3);
    chk("R10 ch1 not busy", {31'd0, rd_data[9]}, 32'd0);
    step(HOLD);
    chk("R10 ch0 done", {30'd0, sel0}, 32'd2);
  endtask

  task automatic t_mask;
    wr(32'h0000_0011); step(1);
    chk("R6 unmasked ignored", rd_data, 32'h0000_0032);
    chk("R6 unmasked sel0", {30'd0, sel0}, 32'd2);
    wr(32'h0001_0001); step(1);
    chk("R6 single bit", {30'd0, sel0}, 32'd3);
    wr(32'h0033_0011); step(1);
    chk("R6 both fields", rd_data, 32'h0000_0011);
    chk("R6 sel1", {30'd0, sel1}, 32'd1);
  endtask

  task automatic t_zero;
    wr(f0(2'b00)); step(1);
    chk("R2 zero refused", rd_data, 32'h0000_1011);
    chk("R2 sel0 kept", {30'd0, sel0}, 32'd1);
    wr(32'h0000_1000); step(1);
    chk("R9 unmasked clear ignored", rd_data, 32'h0000_1011);
    wr(32'h1000_1000); step(1);
    chk("R9 clear", rd_data, 32'h0000_0011);
    wr(32'h0001_0000); step(1);
    chk("R2 partial to zero", rd_data, 32'h0000_1011);
    chk("R2 sel0 still fast", {30'd0, sel0}, 32'd1);
    wr(32'h1000_1000); step(1);
    chk("R9 clear again", rd_data[12] ? 32'd1 : 32'd0, 32'd0);
  endtask

  task automatic t_queue;
    wr(f0(2'b10));
    wr(f0(2'b01));
    wr(f0(2'b10));
    chk("R8 still busy", {30'd0, sel0}, 32'd3);
    step(HOLD - 2);
    chk("R8 hold not restarted", {30'd0, sel0}, 32'd3);
    step(1);
    chk("R8 latest wins", {30'd0, sel0}, 32'd2);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_direct();
    t_through();
    t_indep();
    t_mask();
    t_zero();
    t_queue();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule